// File: doc/BRIEF.md
# Cartridge Program/Character Bank Mapper

This block translates CPU and picture-processor bus addresses into the high address lines and chip controls of a cartridge. The cartridge holds a 64 KiB program ROM and a 64 KiB character RAM. A single write-only bank register is reached through CPU writes anywhere in $8000-$BFFF. The register picks the 16 KiB program bank that appears in that same window. CPU $C000-$FFFF always shows the final program bank.

The register also holds a 4 KiB character bank number for the upper pattern table, PPU $1000-$1FFF. The RAM bank actually addressed there is the bitwise complement of the stored nibble. The lower pattern table, PPU $0000-$0FFF, is pinned to the highest character bank. Nametable mirroring is vertical and fixed. Writes take the data bus as driven by the CPU, with no bus-conflict masking.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset the register holds zero, so CPU $8000-$BFFF maps program bank 0 and PPU $1000-$1FFF maps character bank 15.
- R2: For CPU addresses with A15:A14 = 2'b10, `prg_addr_hi` equals the stored program bank.
- R3: For CPU addresses with A15:A14 = 2'b11, `prg_addr_hi` is 3, whatever has been written.
- R4: A write latches on a rising `clk` edge when `cpu_rw_n` is 0, `cpu_m2` is 1 and A15:A14 = 2'b10. Data bit 7:6 is stored as the program bank and bits 3:0 as the character nibble.
- R5: Data bits 5:4 are ignored. Writing 8'h30 gives the same mapping as writing 8'h00.
- R6: Writes do nothing when the address has A15:A14 = 2'b11, when `cpu_m2` is 0, or when `cpu_rw_n` is 1. The mapping seen at the outputs stays unchanged.
- R7: For PPU A13:A12 = 2'b01, `chr_addr_hi` is the bitwise inverse of the stored nibble. For example, 7 gives 8 and 0 gives 15.
- R8: For PPU A13:A12 = 2'b00, `chr_addr_hi` is 15.
- R9: `ciram_a10` equals PPU A10 (vertical mirroring).
- R10: `prg_ce_n` is 0 only when `cpu_rw_n` is 1 and CPU A15 is 1.
- R11: `chr_ce_n` is 0 exactly when PPU A13 is 0. `chr_we_n` is 0 exactly when PPU A13 is 0 and `ppu_wr_n` is 0. `chr_oe_n` is 0 exactly when PPU A13 is 0 and `ppu_rd_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low reset, clears the bank register |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU data bus (write data) |
| cpu_rw_n | input | 1 | CPU read (1) / write (0) |
| cpu_m2 | input | 1 | CPU bus phase, high while data is valid |
| ppu_addr | input | 14 | PPU address bus |
| ppu_rd_n | input | 1 | PPU read strobe, active low |
| ppu_wr_n | input | 1 | PPU write strobe, active low |
| prg_addr_hi | output | 2 | Program ROM A15:A14 |
| prg_ce_n | output | 1 | Program ROM chip enable, active low |
| chr_addr_hi | output | 4 | Character RAM A15:A12 |
| chr_ce_n | output | 1 | Character RAM chip enable, active low |
| chr_oe_n | output | 1 | Character RAM output enable, active low |
| chr_we_n | output | 1 | Character RAM write enable, active low |
| ciram_a10 | output | 1 | Console nametable RAM A10 |

## Verification
The bank register is the only state in the block, so a wrong register value shows up at the next access to a switchable window. It appears on `prg_addr_hi` for a CPU read of $8000-$BFFF, or on `chr_addr_hi` for a PPU access to $1000-$1FFF, in the first cycle after the faulty edge. A fault that stores the nibble already inverted, or that leaks bits 5:4 into it, moves the upper pattern table to a wrong bank. Such faults are caught by probing both windows after every write. A spurious latch from an out-of-range or strobe-less write changes the mapping at once, so the bench probes both windows after each such write.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
   // Window selectors shared by the mapper submodules and checker
   localparam logic [1:0] CPU_WIN_SWITCH = 2'b10;
   localparam logic [1:0] CPU_WIN_FIXED  = 2'b11;

   typedef enum logic [1:0] {
      PPU_PT_LOW  = 2'b00,
      PPU_PT_HIGH = 2'b01,
      PPU_NT_LOW  = 2'b10,
      PPU_NT_HIGH = 2'b11
   } ppu_region_e;
endpackage

// File: rtl/cbm_bank_reg.sv
module cbm_bank_reg #(
   parameter int CPU_ADDR_W = 16,
   parameter int DATA_W     = 8,
   parameter int PRG_BANK_W = 2,
   parameter int CHR_BANK_W = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [CPU_ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0]     cpu_data,
   input  logic                  cpu_rw_n,
   input  logic                  cpu_m2,
   output logic [PRG_BANK_W-1:0] prg_sel,
   output logic [CHR_BANK_W-1:0] chr_sel
);
   import cbm_pkg::*;

   localparam int MID_W = DATA_W - PRG_BANK_W - CHR_BANK_W;

   initial begin
      assert (MID_W >= 0)
         else $error("bank fields do not fit the data bus");
      assert (CPU_ADDR_W >= 2)
         else $error("CPU address too narrow");
   end

   logic hit;
   logic unused_reg_bits;

   assign hit = !cpu_rw_n && cpu_m2
                && (cpu_addr[CPU_ADDR_W-1 -: 2] == CPU_WIN_SWITCH);

   generate
      if (MID_W > 0) begin : g_mid
         assign unused_reg_bits = ^{cpu_data[CHR_BANK_W +: MID_W],
                                    cpu_addr[CPU_ADDR_W-3:0]};
      end else begin : g_nomid
         assign unused_reg_bits = ^cpu_addr[CPU_ADDR_W-3:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prg_sel <= '0;
         chr_sel <= '0;
      end else if (hit) begin
         prg_sel <= cpu_data[DATA_W-1 -: PRG_BANK_W];
         chr_sel <= cpu_data[CHR_BANK_W-1:0];
      end
   end
endmodule

// File: rtl/cbm_prg_map.sv
module cbm_prg_map #(
   parameter int PRG_BANK_W = 2
) (
   input  logic [1:0]            cpu_win,
   input  logic                  cpu_rw_n,
   input  logic [PRG_BANK_W-1:0] prg_sel,
   output logic [PRG_BANK_W-1:0] prg_addr_hi,
   output logic                  prg_ce_n
);
   import cbm_pkg::*;

   localparam logic [PRG_BANK_W-1:0] LAST_BANK = '1;

   initial begin
      assert (PRG_BANK_W >= 1)
         else $error("program bank width must be positive");
   end

   always_comb begin
      if (cpu_win == CPU_WIN_FIXED) prg_addr_hi = LAST_BANK;
      else                          prg_addr_hi = prg_sel;
   end

   assign prg_ce_n = !(cpu_rw_n && cpu_win[1]);
endmodule

// File: rtl/cbm_chr_map.sv
module cbm_chr_map #(
   parameter int CHR_BANK_W = 4,
   parameter bit INVERT_SEL = 1'b1
) (
   input  logic [1:0]            ppu_region,
   input  logic                  ppu_rd_n,
   input  logic                  ppu_wr_n,
   input  logic [CHR_BANK_W-1:0] chr_sel,
   output logic [CHR_BANK_W-1:0] chr_addr_hi,
   output logic                  chr_ce_n,
   output logic                  chr_oe_n,
   output logic                  chr_we_n
);
   import cbm_pkg::*;

   initial begin
      assert (CHR_BANK_W >= 1)
         else $error("character bank width must be positive");
   end

   logic [CHR_BANK_W-1:0] sw_bank;
   logic [CHR_BANK_W-1:0] fixed_bank;

   generate
      if (INVERT_SEL) begin : g_inv
         assign sw_bank    = ~chr_sel;
         assign fixed_bank = '1;
      end else begin : g_direct
         assign sw_bank    = chr_sel;
         assign fixed_bank = '0;
      end
   endgenerate

   logic pattern;
   assign pattern = !ppu_region[1];

   always_comb begin
      if (ppu_region == PPU_PT_HIGH) chr_addr_hi = sw_bank;
      else                           chr_addr_hi = fixed_bank;
   end

   assign chr_ce_n = !pattern;
   assign chr_oe_n = !(pattern && !ppu_rd_n);
   assign chr_we_n = !(pattern && !ppu_wr_n);
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper #(
   parameter int CPU_ADDR_W = 16,
   parameter int PPU_ADDR_W = 14,
   parameter int DATA_W     = 8,
   parameter int PRG_BANK_W = 2,
   parameter int CHR_BANK_W = 4,
   parameter bit INVERT_CHR = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [CPU_ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0]     cpu_data,
   input  logic                  cpu_rw_n,
   input  logic                  cpu_m2,
   input  logic [PPU_ADDR_W-1:0] ppu_addr,
   input  logic                  ppu_rd_n,
   input  logic                  ppu_wr_n,
   output logic [PRG_BANK_W-1:0] prg_addr_hi,
   output logic                  prg_ce_n,
   output logic [CHR_BANK_W-1:0] chr_addr_hi,
   output logic                  chr_ce_n,
   output logic                  chr_oe_n,
   output logic                  chr_we_n,
   output logic                  ciram_a10
);
   localparam int PT_MSB = PPU_ADDR_W - 1;

   initial begin
      assert (PPU_ADDR_W >= 12)
         else $error("PPU address must reach A11");
   end

   logic [PRG_BANK_W-1:0] prg_sel;
   logic [CHR_BANK_W-1:0] chr_sel;
   logic                  unused_ppu_bits;

   assign unused_ppu_bits = ^{ppu_addr[PT_MSB-2], ppu_addr[PT_MSB-3],
                              ppu_addr[9:0]};

   cbm_bank_reg #(
      .CPU_ADDR_W(CPU_ADDR_W), .DATA_W(DATA_W),
      .PRG_BANK_W(PRG_BANK_W), .CHR_BANK_W(CHR_BANK_W)
   ) u_reg (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
      .cpu_rw_n(cpu_rw_n), .cpu_m2(cpu_m2),
      .prg_sel(prg_sel), .chr_sel(chr_sel)
   );

   cbm_prg_map #(.PRG_BANK_W(PRG_BANK_W)) u_prg (
      .cpu_win(cpu_addr[CPU_ADDR_W-1 -: 2]), .cpu_rw_n(cpu_rw_n),
      .prg_sel(prg_sel), .prg_addr_hi(prg_addr_hi), .prg_ce_n(prg_ce_n)
   );

   cbm_chr_map #(.CHR_BANK_W(CHR_BANK_W), .INVERT_SEL(INVERT_CHR)) u_chr (
      .ppu_region(ppu_addr[PT_MSB -: 2]), .ppu_rd_n(ppu_rd_n),
      .ppu_wr_n(ppu_wr_n), .chr_sel(chr_sel), .chr_addr_hi(chr_addr_hi),
      .chr_ce_n(chr_ce_n), .chr_oe_n(chr_oe_n), .chr_we_n(chr_we_n)
   );

   assign ciram_a10 = ppu_addr[10];
endmodule

// File: rtl/cbm_checker.sv
module cbm_checker #(
   parameter int CPU_ADDR_W = 16,
   parameter int PPU_ADDR_W = 14,
   parameter int DATA_W     = 8,
   parameter int PRG_BANK_W = 2,
   parameter int CHR_BANK_W = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [CPU_ADDR_W-1:0] cpu_addr,
   input logic [DATA_W-1:0]     cpu_data,
   input logic                  cpu_rw_n,
   input logic                  cpu_m2,
   input logic [PPU_ADDR_W-1:0] ppu_addr,
   input logic                  ppu_wr_n,
   input logic [PRG_BANK_W-1:0] prg_addr_hi,
   input logic                  prg_ce_n,
   input logic [CHR_BANK_W-1:0] chr_addr_hi,
   input logic                  chr_ce_n,
   input logic                  chr_we_n,
   input logic [PRG_BANK_W-1:0] prg_sel,
   input logic [CHR_BANK_W-1:0] chr_sel
);
   logic wr_hit;
   assign wr_hit = !cpu_rw_n && cpu_m2 && (cpu_addr[CPU_ADDR_W-1 -: 2] == 2'b10);

   p_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> (prg_sel == $past(cpu_data[DATA_W-1 -: PRG_BANK_W]))
                 && (chr_sel == $past(cpu_data[CHR_BANK_W-1:0])));

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> $stable(prg_sel) && $stable(chr_sel));

   p_fixed_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr[CPU_ADDR_W-1 -: 2] == 2'b11) |-> (prg_addr_hi == '1));

   p_switch_prg_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr[CPU_ADDR_W-1 -: 2] == 2'b10) |-> (prg_addr_hi == prg_sel));

   p_fixed_low_chr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ppu_addr[PPU_ADDR_W-1 -: 2] == 2'b00) |-> (chr_addr_hi == '1));

   p_invert_chr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ppu_addr[PPU_ADDR_W-1 -: 2] == 2'b01) |-> (chr_addr_hi == ~chr_sel));

   p_no_ce_on_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_rw_n |-> prg_ce_n);

   p_we_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !chr_we_n |-> (!chr_ce_n && !ppu_wr_n));
endmodule

bind cart_bank_mapper cbm_checker #(
   .CPU_ADDR_W(CPU_ADDR_W), .PPU_ADDR_W(PPU_ADDR_W), .DATA_W(DATA_W),
   .PRG_BANK_W(PRG_BANK_W), .CHR_BANK_W(CHR_BANK_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
   .cpu_rw_n(cpu_rw_n), .cpu_m2(cpu_m2), .ppu_addr(ppu_addr),
   .ppu_wr_n(ppu_wr_n), .prg_addr_hi(prg_addr_hi), .prg_ce_n(prg_ce_n),
   .chr_addr_hi(chr_addr_hi), .chr_ce_n(chr_ce_n), .chr_we_n(chr_we_n),
   .prg_sel(prg_sel), .chr_sel(chr_sel)
);

// File: tb/sim_cart_bank_mapper.sv
`timescale 1ns/1ps
module sim_cart_bank_mapper;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = 16'h0000;
   logic [7:0]  cpu_data = 8'h00;
   logic        cpu_rw_n = 1'b1;
   logic        cpu_m2 = 1'b0;
   logic [13:0] ppu_addr = 14'h0000;
   logic        ppu_rd_n = 1'b1;
   logic        ppu_wr_n = 1'b1;
   logic [1:0]  prg_addr_hi;
   logic        prg_ce_n;
   logic [3:0]  chr_addr_hi;
   logic        chr_ce_n, chr_oe_n, chr_we_n, ciram_a10;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   cart_bank_mapper u0 (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
      .cpu_rw_n(cpu_rw_n), .cpu_m2(cpu_m2), .ppu_addr(ppu_addr),
      .ppu_rd_n(ppu_rd_n), .ppu_wr_n(ppu_wr_n), .prg_addr_hi(prg_addr_hi),
      .prg_ce_n(prg_ce_n), .chr_addr_hi(chr_addr_hi), .chr_ce_n(chr_ce_n),
      .chr_oe_n(chr_oe_n), .chr_we_n(chr_we_n), .ciram_a10(ciram_a10)
   );

   // {write data, expected program bank, expected character bank}
   localparam logic [13:0] VECS [8] = '{
      {8'h00, 2'd0, 4'd15}, {8'h47, 2'd1, 4'd8},
      {8'h8F, 2'd2, 4'd0},  {8'hC3, 2'd3, 4'd12},
      {8'h30, 2'd0, 4'd15}, {8'h7A, 2'd1, 4'd5},
      {8'hB1, 2'd2, 4'd14}, {8'hE5, 2'd3, 4'd10}
   };

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cpu_write(logic [15:0] a, logic [7:0] d, logic m2);
      @(negedge clk);
      cpu_addr = a; cpu_data = d; cpu_rw_n = 1'b0; cpu_m2 = m2;
      @(negedge clk);
      cpu_rw_n = 1'b1; cpu_m2 = 1'b0;
   endtask

   task automatic probe(string req, int exp_prg, int exp_chr);
      cpu_rw_n = 1'b1;
      cpu_addr = 16'h9ABC; ppu_addr = 14'h1234; #1;
      chk({req, " prg window"}, prg_addr_hi, exp_prg);
      chk({req, " chr window"}, chr_addr_hi, exp_chr);
      cpu_addr = 16'hD001; ppu_addr = 14'h0567; #1;
      chk("R3 fixed prg", prg_addr_hi, 3);
      chk("R8 fixed chr", chr_addr_hi, 15);
   endtask

   initial begin
      #200000;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      probe("R1 reset", 0, 15);

      // R2 R4 R5 R7: table walk
      foreach (VECS[i]) begin
         cpu_write(16'h8000 | 16'(i * 16'h0731), VECS[i][13:6], 1'b1);
         probe("R4/R7 table", int'(VECS[i][5:4]), int'(VECS[i][3:0]));
      end

      // R5: bits 5:4 alone
      cpu_write(16'hA000, 8'h47, 1'b1);
      cpu_write(16'hBFFF, 8'h77, 1'b1);
      probe("R5 ignored bits", 1, 8);

      // R6: writes that must not latch
      cpu_write(16'hC000, 8'hFF, 1'b1);
      probe("R6 upper range", 1, 8);
      cpu_write(16'h8000, 8'hFF, 1'b0);
      probe("R6 m2 low", 1, 8);
      @(negedge clk);
      cpu_addr = 16'h8000; cpu_data = 8'hFF; cpu_rw_n = 1'b1; cpu_m2 = 1'b1;
      @(negedge clk);
      cpu_m2 = 1'b0;
      probe("R6 read cycle", 1, 8);

      // R9 mirroring
      ppu_addr = 14'h2400; #1; chk("R9 a10 high", ciram_a10, 1);
      ppu_addr = 14'h2BFF; #1; chk("R9 a10 low", ciram_a10, 0);

      // R10 program enable
      cpu_rw_n = 1'b1; cpu_addr = 16'h8000; #1; chk("R10 read 8000", prg_ce_n, 0);
      cpu_addr = 16'hFFFC; #1; chk("R10 read FFFC", prg_ce_n, 0);
      cpu_addr = 16'h6000; #1; chk("R10 read 6000", prg_ce_n, 1);
      cpu_rw_n = 1'b0; cpu_addr = 16'hC000; #1; chk("R10 write C000", prg_ce_n, 1);
      cpu_rw_n = 1'b1;

      // R11 character strobes
      ppu_addr = 14'h1000; ppu_wr_n = 1'b0; #1;
      chk("R11 we pattern", chr_we_n, 0);
      chk("R11 ce pattern", chr_ce_n, 0);
      chk("R11 oe idle", chr_oe_n, 1);
      ppu_addr = 14'h2000; #1;
      chk("R11 we nametable", chr_we_n, 1);
      chk("R11 ce nametable", chr_ce_n, 1);
      ppu_wr_n = 1'b1; ppu_rd_n = 1'b0; ppu_addr = 14'h0500; #1;
      chk("R11 oe pattern", chr_oe_n, 0);
      chk("R11 we idle", chr_we_n, 1);
      ppu_addr = 14'h3F00; #1;
      chk("R11 oe nametable", chr_oe_n, 1);
      ppu_rd_n = 1'b1;

      // R1: reset again after a nonzero value
      cpu_write(16'h8000, 8'hC5, 1'b1);
      probe("R4 before reset", 3, 10);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      probe("R1 second reset", 0, 15);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule